// File: doc/BRIEF.md
# Per-Element Variable Vector Shifter

This block shifts every element of a packed data vector by its own amount. The amount for element *i* is read from element *i* of a second packed vector, the count vector, so that each element moves independently. Three kinds of shift are offered: logical left, logical right, and arithmetic right. Elements are 32 or 64 bits wide. The vector is either full width (256 bits by default) or narrow (the low half, 128 bits by default).

A caller presents one operation per cycle with `in_valid`. The shifted vector appears on the registered outputs one clock later, and `out_valid` marks it. Arithmetic right shift is defined only for 32-bit elements. A request for a 64-bit arithmetic shift, or for the reserved operation code, raises `out_illegal` and returns a zero vector.

Top module: `pelem_vshift`

## Requirements
- R1: With `in_op`=0 (logical left), element i of the result is element i of `in_data` shifted left by element i of `in_cnt`, zero filled. Element i occupies bits [i*EW +: EW], where EW=32 when `in_esz`=0 and EW=64 when `in_esz`=1.
- R2: With `in_op`=1 (logical right), each element is shifted right by its own count and zero filled, for both element sizes.
- R3: With `in_op`=2 (arithmetic right) and `in_esz`=0, each 32-bit element is shifted right by its own count and filled with copies of its bit 31.
- R4: `in_op`=2 together with `in_esz`=1, and `in_op`=3 (reserved), are illegal. They set `out_illegal`=1 and produce an all-zero `out_data`. Every legal request clears `out_illegal`.
- R5: The count is the whole element taken as unsigned. A count of EW or more gives zero for the logical shifts and the sign-bit fill for the arithmetic shift.
- R6: With `in_wide`=0 only the low 128 bits are processed, and bits [255:128] of `out_data` are zero whatever the inputs hold there. With `in_wide`=1 all 256 bits are processed.
- R7: An element whose count is zero comes out unchanged for every legal operation.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. The result of an accepted request appears in that same cycle.
- R9: In a cycle without `in_valid`, `out_data` and `out_illegal` keep their previous values.
- R10: While `rst_n` is low, `out_valid`, `out_illegal` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted this cycle |
| in_op | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 reserved |
| in_esz | input | 1 | Element size: 0 = 32 bits, 1 = 64 bits |
| in_wide | input | 1 | 1 = full vector, 0 = low half only |
| in_data | input | 256 | Packed data operand |
| in_cnt | input | 256 | Packed per-element shift counts |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Request was an illegal combination |
| out_data | output | 256 | Packed shifted result |

## Verification
Random data is paired with counts that differ from element to element. A shifter that uses one shared count, or that takes its count from the wrong element, therefore shows up at once. Directed counts of 0, EW-1, EW and 0xFFFFFFFF, on negative and positive elements, test the unsigned saturation rule. They also separate sign fill from zero fill and a 5-bit count from a 6-bit count. Narrow requests carry nonzero upper-half operands, which exposes any leak into bits [255:128]. Idle gaps after each kind of request show whether the output register holds its value or is overwritten.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
   typedef enum logic [1:0] {
      OP_SHL = 2'd0,
      OP_SHR = 2'd1,
      OP_SAR = 2'd2,
      OP_RSV = 2'd3
   } sh_op_e;

   localparam int unsigned NARROW_EW = 32;
   localparam int unsigned WIDE_EW   = 64;
endpackage

// File: rtl/vshift_elem.sv
// One element shifter. HAS_SAR selects whether the arithmetic variant exists.
module vshift_elem
   import vshift_pkg::*;
#(
   parameter int unsigned EW      = 32,
   parameter bit          HAS_SAR = 1'b1
) (
   input  logic [EW-1:0] d,
   input  logic [EW-1:0] c,
   input  sh_op_e        op,
   output logic [EW-1:0] r
);
   localparam int unsigned SW = $clog2(EW);

   if (EW < 2 || (1 << SW) != EW) begin : g_bad_ew
      $error("vshift_elem: EW must be a power of two >= 2");
   end

   logic          big;
   logic [SW-1:0] amt;
   logic [EW-1:0] sar_r;

   // Count is unsigned over the whole element: any high bit set saturates.
   assign big = |c[EW-1:SW];
   assign amt = c[SW-1:0];

   if (HAS_SAR) begin : g_sar
      always_comb begin
         if (big) sar_r = {EW{d[EW-1]}};
         else     sar_r = EW'($signed(d) >>> amt);
      end
   end else begin : g_nosar
      assign sar_r = '0;
   end

   always_comb begin
      unique case (op)
         OP_SHL:  r = big ? '0 : (d << amt);
         OP_SHR:  r = big ? '0 : (d >> amt);
         OP_SAR:  r = sar_r;
         default: r = '0;
      endcase
   end
endmodule

// File: rtl/vshift_core.sv
// Combinational vector datapath: two lane arrays, element-size select,
// narrow-mode clearing and illegal-combination detection.
module vshift_core
   import vshift_pkg::*;
#(
   parameter int unsigned VEC_W = 256
) (
   input  sh_op_e           op,
   input  logic             esz,
   input  logic             wide,
   input  logic [VEC_W-1:0] data,
   input  logic [VEC_W-1:0] cnt,
   output logic [VEC_W-1:0] res,
   output logic             illegal
);
   localparam int unsigned NARROW_W = VEC_W / 2;
   localparam int unsigned N32      = VEC_W / NARROW_EW;
   localparam int unsigned N64      = VEC_W / WIDE_EW;

   if (VEC_W < 128 || (VEC_W % 128) != 0) begin : g_bad_vec
      $error("vshift_core: VEC_W must be a multiple of 128");
   end

   logic [VEC_W-1:0] r32, r64, sel;

   for (genvar i = 0; i < N32; i++) begin : g_e32
      vshift_elem #(.EW(NARROW_EW), .HAS_SAR(1'b1)) u_e (
         .d  (data[i*NARROW_EW +: NARROW_EW]),
         .c  (cnt [i*NARROW_EW +: NARROW_EW]),
         .op (op),
         .r  (r32 [i*NARROW_EW +: NARROW_EW])
      );
   end

   for (genvar j = 0; j < N64; j++) begin : g_e64
      vshift_elem #(.EW(WIDE_EW), .HAS_SAR(1'b0)) u_e (
         .d  (data[j*WIDE_EW +: WIDE_EW]),
         .c  (cnt [j*WIDE_EW +: WIDE_EW]),
         .op (op),
         .r  (r64 [j*WIDE_EW +: WIDE_EW])
      );
   end

   assign illegal = (op == OP_RSV) || (op == OP_SAR && esz);
   assign sel     = esz ? r64 : r32;

   always_comb begin
      if (illegal)   res = '0;
      else if (wide) res = sel;
      else           res = {{(VEC_W-NARROW_W){1'b0}}, sel[NARROW_W-1:0]};
   end
endmodule

// File: rtl/pelem_vshift.sv
module pelem_vshift
   import vshift_pkg::*;
#(
   parameter int unsigned VEC_W = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic             in_esz,
   input  logic             in_wide,
   input  logic [VEC_W-1:0] in_data,
   input  logic [VEC_W-1:0] in_cnt,
   output logic             out_valid,
   output logic             out_illegal,
   output logic [VEC_W-1:0] out_data
);
   logic [VEC_W-1:0] res;
   logic             illegal;

   vshift_core #(.VEC_W(VEC_W)) u_core (
      .op      (sh_op_e'(in_op)),
      .esz     (in_esz),
      .wide    (in_wide),
      .data    (in_data),
      .cnt     (in_cnt),
      .res     (res),
      .illegal (illegal)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal <= illegal;
            out_data    <= res;
         end
      end
   end
endmodule

// File: rtl/vshift_chk.sv
module vshift_chk #(
   parameter int unsigned VEC_W = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_op,
   input logic             in_esz,
   input logic             in_wide,
   input logic [VEC_W-1:0] in_data,
   input logic [VEC_W-1:0] in_cnt,
   input logic             out_valid,
   input logic             out_illegal,
   input logic [VEC_W-1:0] out_data
);
   localparam int unsigned HALF = VEC_W / 2;

   // R8: valid follows the request by exactly one clock
   a_r8_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R4: illegal combinations flag and zero the result
   a_r4_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == 2'd3 || (in_op == 2'd2 && in_esz)))
      |=> (out_illegal && out_data == '0));

   // R6: narrow requests leave the upper half zero
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wide) |=> (out_data[VEC_W-1:HALF] == '0));

   // R7: all-zero counts pass a legal full-width vector through
   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_wide && in_cnt == '0 && in_op != 2'd3
       && !(in_op == 2'd2 && in_esz))
      |=> (out_data == $past(in_data) && !out_illegal));

   // R9: outputs hold while idle
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_illegal)));
endmodule

bind pelem_vshift vshift_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_pelem_vshift.sv
`timescale 1ns/1ps
module sim_pelem_vshift;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_op = '0;
   logic         in_esz = 1'b0;
   logic         in_wide = 1'b0;
   logic [255:0] in_data = '0;
   logic [255:0] in_cnt = '0;
   logic         out_valid, out_illegal;
   logic [255:0] out_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic         exp_valid = 1'b0;
   logic         exp_ill   = 1'b0;
   logic [255:0] exp_data  = '0;
   string        exp_tag   = "R10 reset";

   always #2 clk = ~clk;

   pelem_vshift u0 (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [255:0] ref_out(logic [1:0] op, bit esz, bit wide,
                                            logic [255:0] d, logic [255:0] c);
      int ew, n;
      logic [255:0] acc;
      logic [63:0]  mask, x, k, y;
      logic         sgn;
      ew   = esz ? 64 : 32;
      n    = (wide ? 256 : 128) / ew;
      mask = esz ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      acc  = '0;
      if (op == 2'd3 || (op == 2'd2 && esz)) return '0;
      for (int e = 0; e < n; e++) begin
         x   = 64'(d >> (e*ew)) & mask;
         k   = 64'(c >> (e*ew)) & mask;
         sgn = x[ew-1];
         if (k >= 64'(ew))
            y = (op == 2'd2 && sgn) ? mask : 64'd0;
         else if (op == 2'd0)
            y = (x << k) & mask;
         else if (op == 2'd1)
            y = x >> k;
         else
            y = (x >> k) | (sgn ? (mask & ~(mask >> k)) : 64'd0);
         acc = acc | (256'(y) << (e*ew));
      end
      return acc;
   endfunction

   task automatic compare();
      checks++;
      if (out_valid !== exp_valid || out_illegal !== exp_ill || out_data !== exp_data) begin
         errors++;
         $display("FAIL %s valid %0b exp %0b illegal %0b exp %0b data %h exp %h",
                  exp_tag, out_valid, exp_valid, out_illegal, exp_ill, out_data, exp_data);
      end
   endtask

   task automatic step(bit v, logic [1:0] op, bit esz, bit wide,
                       logic [255:0] d, logic [255:0] c, string tag);
      @(negedge clk);
      compare();
      in_valid = v; in_op = op; in_esz = esz; in_wide = wide;
      in_data = d; in_cnt = c;
      exp_valid = v;
      if (v) begin
         exp_data = ref_out(op, esz, wide, d, c);
         exp_ill  = (op == 2'd3) || (op == 2'd2 && esz);
         exp_tag  = tag;
      end else begin
         exp_tag = "R9 idle hold";
      end
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // per-element counts, mostly in range, some saturating
   function automatic logic [255:0] rnd_cnt(bit esz);
      logic [255:0] v;
      int ew;
      ew = esz ? 64 : 32;
      v = '0;
      for (int e = 0; e < 256/ew; e++) begin
         case ($urandom % 6)
            0: v[e*ew +: 32] = 32'(ew);
            1: v[e*ew +: 32] = 32'hFFFF_FFFF;
            default: v[e*ew +: 32] = $urandom % ew;
         endcase
      end
      return v;
   endfunction

   function automatic logic [255:0] fill_cnt(bit esz, logic [31:0] val);
      logic [255:0] v;
      int ew;
      ew = esz ? 64 : 32;
      v = '0;
      for (int e = 0; e < 256/ew; e++) v[e*ew +: 32] = val;
      return v;
   endfunction

   initial begin
      logic [255:0] neg;
      neg = {8{32'h8000_00F1}};
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();                         // R10 reset state
      rst_n = 1'b1;

      // R1 R2 R3: random data, element-distinct counts, every mode
      for (int i = 0; i < 40; i++)
         step(1, 2'd0, i[0], 1'b1, rnd256(), rnd_cnt(i[0]), "R1 shl random");
      for (int i = 0; i < 40; i++)
         step(1, 2'd1, i[0], 1'b1, rnd256(), rnd_cnt(i[0]), "R2 shr random");
      for (int i = 0; i < 40; i++)
         step(1, 2'd2, 1'b0, 1'b1, rnd256(), rnd_cnt(1'b0), "R3 sar random");

      // R5 saturation boundaries: EW-1, EW, all ones
      step(1, 2'd0, 0, 1, neg, fill_cnt(0, 32'd31), "R5 shl32 count 31");
      step(1, 2'd0, 0, 1, neg, fill_cnt(0, 32'd32), "R5 shl32 count 32");
      step(1, 2'd1, 1, 1, ~neg, fill_cnt(1, 32'd63), "R5 shr64 count 63");
      step(1, 2'd1, 1, 1, ~neg, fill_cnt(1, 32'd64), "R5 shr64 count 64");
      step(1, 2'd1, 0, 1, neg, fill_cnt(0, 32'hFFFF_FFFF), "R5 shr32 count max");
      step(1, 2'd2, 0, 1, neg, fill_cnt(0, 32'd32), "R5 sar32 neg count 32");
      step(1, 2'd2, 0, 1, ~neg, fill_cnt(0, 32'hFFFF_FFFF), "R5 sar32 pos count max");
      step(1, 2'd2, 0, 1, neg, fill_cnt(0, 32'd31), "R3 sar32 neg count 31");
      step(1, 2'd0, 1, 1, neg, {4{64'h0000_0001_0000_0000}}, "R5 shl64 high-word count");

      // R7 zero counts
      step(1, 2'd0, 1, 1, neg, '0, "R7 shl zero count");
      step(1, 2'd2, 0, 1, neg, '0, "R7 sar zero count");

      // R4 illegal combinations, then legal clears flag
      step(1, 2'd2, 1, 1, neg, fill_cnt(1, 32'd3), "R4 sar64 illegal");
      step(0, 2'd0, 0, 1, '0, '0, "R9 idle");
      step(1, 2'd3, 0, 1, neg, fill_cnt(0, 32'd3), "R4 reserved op");
      step(1, 2'd1, 0, 1, neg, fill_cnt(0, 32'd3), "R4 legal clears flag");

      // R6 narrow mode with junk in the upper half
      for (int i = 0; i < 20; i++)
         step(1, 2'(i % 3), (i % 3 == 2) ? 1'b0 : i[0], 1'b0,
              rnd256(), rnd_cnt(i[0]), "R6 narrow");

      // R8 R9 idle gaps between requests
      for (int i = 0; i < 10; i++) begin
         step(1, 2'(i % 2), i[1], i[0], rnd256(), rnd_cnt(i[1]), "R8 single beat");
         step(0, 2'd0, 0, 0, rnd256(), rnd256(), "R9 idle");
         step(0, 2'd2, 1, 1, rnd256(), rnd256(), "R9 idle");
      end

      step(0, 2'd0, 0, 0, '0, '0, "R9 flush");
      @(negedge clk);
      compare();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule